// File: doc/BRIEF.md
# Multi-lane serial flash command front end

This block is the target-side front end of a serial NOR memory. It sits on a serial bus framed by an active-low chip select and carrying one, two or four data lanes. It takes in an instruction byte and then a 24-bit address and write bytes, and passes them to a memory-side port as a decoded opcode, an address, write strobes and read requests. For reads it sends the returned bytes back on the lanes that are in use. All serial inputs are oversampled by the system clock, so the block has one clock domain. Bus clock edges are found by comparing the bus clock with its value one system clock earlier.

One of three framing protocols is active at any time. In extended framing the opcode always travels on lane 0 alone, and the opcode chooses how many lanes the address and data use. In dual framing every phase uses lanes 0 and 1. In quad framing every phase uses all four lanes. A reset loads the protocol from a non-volatile configuration input. A volatile configuration write frame can change it at run time, and the change applies once chip select is released. The protocol never changes in the middle of a frame.

Top module: `flash_cmd_front`

## Requirements
- R1: While `rst` is high, `proto` is loaded from `nv_cfg`. Bit 3 = 0 selects quad (2). Otherwise bit 2 = 0 selects dual (1). Otherwise extended (0) is selected. Any earlier volatile selection is lost. `proto` never takes the value 3.
- R2: A volatile configuration frame is opcode 0x61 followed by one byte. When chip select rises after that byte is complete, bit 7 = 0 selects quad, otherwise bit 6 = 0 selects dual, otherwise extended. `proto` keeps its old value until chip select rises.
- R3: The opcode uses lane 0 alone in extended framing, lanes 1:0 in dual framing and lanes 3:0 in quad framing. In every multi-lane group, the higher-numbered lane carries the more significant bit, and bits go most significant first.
- R4: In extended framing, 0x03 reads with address and data on one lane, 0x3B reads on two lanes, 0x6B reads on four lanes, 0x02 writes on one lane, and 0x61 carries its byte on one lane. In dual and quad framing, only 0x03, 0x02 and 0x61 are recognised, and they use the full width.
- R5: A read or write opcode is followed directly by a 24-bit address, most significant bit first, with no dummy cycles.
- R6: Each completed write byte produces a single-cycle `mem_we` with `mem_addr` and `mem_wdata`. The address increases by one for each byte.
- R7: A read presents the byte at the received address and then the following bytes, with the address wrapping at 24 bits. Each byte goes out most significant bits first on the active lanes. `dq_out` and `dq_oe` change only after a falling bus clock edge.
- R8: After an unrecognised opcode, the block issues no strobe, no read request and no `op_valid`, and it drives no lane until chip select rises.
- R9: If chip select rises before an opcode, address, write byte or configuration byte is complete, that unit has no effect. The next frame is decoded from its first bit.
- R10: `dq_oe` is zero outside the read data phase, and it is zero whenever chip select is high.
- R11: A recognised opcode produces a single-cycle `op_valid` with the opcode on `cmd_op`.
- R12: The bus clock may idle low or idle high. Inputs are captured on rising edges in both cases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| nv_cfg | input | 8 | Non-volatile configuration value |
| sck | input | 1 | Serial bus clock |
| cs_n | input | 1 | Active-low chip select |
| dq_in | input | 4 | Incoming lane values |
| dq_out | output | 4 | Outgoing lane values |
| dq_oe | output | 4 | Per-lane output enable |
| proto | output | 2 | Active protocol: 0 extended, 1 dual, 2 quad |
| op_valid | output | 1 | Recognised opcode pulse |
| cmd_op | output | 8 | Last received opcode |
| mem_addr | output | 24 | Memory address |
| mem_re | output | 1 | Read request pulse |
| mem_rdata | input | 8 | Read data, valid from the cycle after `mem_re` |
| mem_we | output | 1 | Write strobe pulse |
| mem_wdata | output | 8 | Write data |

## Verification
A bus clock rise is captured on the first system clock edge that sees it. Write strobes, `op_valid` and read requests appear on that same edge. `dq_out` changes on the first system edge after a fall, and `proto` changes two system edges after chip select rises. The bench holds each bus clock level for two system clocks and samples lanes just before the next rise. It records pulses with monitors on the falling system edge, and it checks `proto` a few cycles after deselect, so every check falls after its result is due.

// File: rtl/flash_front_pkg.sv
package flash_front_pkg;
  typedef enum logic [1:0] {PR_EXT = 2'd0, PR_DUAL = 2'd1, PR_QUAD = 2'd2} proto_t;
  typedef enum logic [2:0] {PH_OP, PH_ADDR, PH_WR, PH_RD, PH_VC, PH_IGN} phase_t;

  localparam logic [7:0] OP_RD1  = 8'h03;
  localparam logic [7:0] OP_RD2  = 8'h3B;
  localparam logic [7:0] OP_RD4  = 8'h6B;
  localparam logic [7:0] OP_PROG = 8'h02;
  localparam logic [7:0] OP_VCFG = 8'h61;

  function automatic logic [2:0] op_lanes(proto_t p);
    case (p)
      PR_EXT:  return 3'd1;
      PR_DUAL: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [2:0] body_lanes(proto_t p, logic [7:0] op);
    if (p != PR_EXT) return op_lanes(p);
    if (op == OP_RD2) return 3'd2;
    if (op == OP_RD4) return 3'd4;
    return 3'd1;
  endfunction

  function automatic logic op_known(proto_t p, logic [7:0] op);
    if (op == OP_RD1 || op == OP_PROG || op == OP_VCFG) return 1'b1;
    return (p == PR_EXT) && (op == OP_RD2 || op == OP_RD4);
  endfunction

  function automatic proto_t cfg_pick(logic quad_n, logic dual_n);
    if (!quad_n) return PR_QUAD;
    if (!dual_n) return PR_DUAL;
    return PR_EXT;
  endfunction
endpackage

// File: rtl/ffe_mode_reg.sv
module ffe_mode_reg
  import flash_front_pkg::*;
#(
  parameter int CFG_W       = 8,
  parameter int NV_DUAL_BIT = 2,
  parameter int NV_QUAD_BIT = 3,
  parameter int V_DUAL_BIT  = 6,
  parameter int V_QUAD_BIT  = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] nv_cfg,
  input  logic             upd,
  input  logic [CFG_W-1:0] vbyte,
  output proto_t           proto
);
  always_ff @(posedge clk) begin
    if (rst)
      proto <= cfg_pick(nv_cfg[NV_QUAD_BIT], nv_cfg[NV_DUAL_BIT]);
    else if (upd)
      proto <= cfg_pick(vbyte[V_QUAD_BIT], vbyte[V_DUAL_BIT]);
  end

  assert_proto_legal_R1: assert property (@(posedge clk) disable iff (rst)
    proto != 2'd3);
  assert_proto_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(proto));
endmodule

// File: rtl/ffe_tx_ser.sv
module ffe_tx_ser #(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  localparam int LW_W  = $clog2(BYTE_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              fall,
  input  logic [2:0]        lanes,
  input  logic [BYTE_W-1:0] rdata,
  output logic [LANES-1:0]  dq_out,
  output logic [LANES-1:0]  dq_oe,
  output logic              empty
);
  logic [BYTE_W-1:0] sh, src;
  logic [LW_W-1:0]   left;

  assign empty = (left == '0);
  assign src   = empty ? rdata : sh;

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      sh     <= '0;
      left   <= '0;
      dq_out <= '0;
      dq_oe  <= '0;
    end else if (fall) begin
      left <= (empty ? LW_W'(BYTE_W) : left) - LW_W'(lanes);
      case (lanes)
        3'd1: begin
          dq_out <= LANES'(src[BYTE_W-1]);
          dq_oe  <= LANES'(1);
          sh     <= src << 1;
        end
        3'd2: begin
          dq_out <= LANES'(src[BYTE_W-1 -: 2]);
          dq_oe  <= LANES'(3);
          sh     <= src << 2;
        end
        default: begin
          dq_out <= LANES'(src[BYTE_W-1 -: 4]);
          dq_oe  <= LANES'(15);
          sh     <= src << 4;
        end
      endcase
    end
  end

  assert_oe_mask_R7: assert property (@(posedge clk) disable iff (rst)
    dq_oe == 0 || dq_oe == 1 || dq_oe == 3 || dq_oe == 15);
  assert_drive_after_fall_R7: assert property (@(posedge clk) disable iff (rst)
    (fall && active) |=> dq_oe != 0);
endmodule

// File: rtl/flash_cmd_front.sv
module flash_cmd_front
  import flash_front_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CFG_W  = 8,
  parameter int LANES  = 4,
  localparam int CNT_W = $clog2(ADDR_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CFG_W-1:0]  nv_cfg,
  input  logic              sck,
  input  logic              cs_n,
  input  logic [LANES-1:0]  dq_in,
  output logic [LANES-1:0]  dq_out,
  output logic [LANES-1:0]  dq_oe,
  output logic [1:0]        proto,
  output logic              op_valid,
  output logic [7:0]        cmd_op,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_re,
  input  logic [7:0]        mem_rdata,
  output logic              mem_we,
  output logic [7:0]        mem_wdata
);
  proto_t            cur;
  phase_t            ph;
  logic              sck_q, rise, fall, unit_done, tx_empty, upd, vhave;
  logic [2:0]        lw;
  logic [CNT_W-1:0]  cnt, cnt_nx, need;
  logic [ADDR_W-1:0] sh_in, nx, addr;
  logic [7:0]        op_q;
  logic [CFG_W-1:0]  vbyte;

  assign rise      = sck && !sck_q && !cs_n;
  assign fall      = !sck && sck_q && !cs_n;
  assign cnt_nx    = cnt + CNT_W'(lw);
  assign need      = (ph == PH_ADDR) ? CNT_W'(ADDR_W) : CNT_W'(8);
  assign unit_done = (cnt_nx == need);
  assign proto     = cur;

  always_comb begin
    case (lw)
      3'd1:    nx = {sh_in[ADDR_W-2:0], dq_in[0]};
      3'd2:    nx = {sh_in[ADDR_W-3:0], dq_in[1:0]};
      default: nx = {sh_in[ADDR_W-5:0], dq_in[3:0]};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q <= 1'b0; ph <= PH_OP; cnt <= '0; lw <= 3'd1; sh_in <= '0;
      addr <= '0; op_q <= '0; vbyte <= '0; vhave <= 1'b0; upd <= 1'b0;
      op_valid <= 1'b0; cmd_op <= '0; mem_addr <= '0; mem_re <= 1'b0;
      mem_we <= 1'b0; mem_wdata <= '0;
    end else begin
      sck_q    <= sck;
      op_valid <= 1'b0;
      mem_we   <= 1'b0;
      mem_re   <= 1'b0;
      upd      <= 1'b0;
      if (cs_n) begin
        ph    <= PH_OP;
        cnt   <= '0;
        sh_in <= '0;
        lw    <= op_lanes(cur);
        upd   <= vhave;
        vhave <= 1'b0;
      end else if (rise) begin
        sh_in <= nx;
        cnt   <= unit_done ? '0 : cnt_nx;
        if (unit_done) begin
          case (ph)
            PH_OP: begin
              cmd_op <= nx[7:0];
              op_q   <= nx[7:0];
              if (op_known(cur, nx[7:0])) begin
                op_valid <= 1'b1;
                lw       <= body_lanes(cur, nx[7:0]);
                ph       <= (nx[7:0] == OP_VCFG) ? PH_VC : PH_ADDR;
              end else begin
                ph <= PH_IGN;
              end
            end
            PH_ADDR: begin
              addr <= nx;
              if (op_q == OP_PROG) ph <= PH_WR;
              else begin
                ph       <= PH_RD;
                mem_addr <= nx;
                mem_re   <= 1'b1;
              end
            end
            PH_WR: begin
              mem_we    <= 1'b1;
              mem_wdata <= nx[7:0];
              mem_addr  <= addr;
              addr      <= addr + 1'b1;
            end
            PH_VC: begin
              vbyte <= CFG_W'(nx[7:0]);
              vhave <= 1'b1;
              ph    <= PH_IGN;
            end
            default: ;
          endcase
        end
      end else if (fall && ph == PH_RD && tx_empty) begin
        addr     <= addr + 1'b1;
        mem_addr <= addr + 1'b1;
        mem_re   <= 1'b1;
      end
    end
  end

  ffe_mode_reg #(.CFG_W(CFG_W)) u_mode (
    .clk(clk), .rst(rst), .nv_cfg(nv_cfg), .upd(upd), .vbyte(vbyte), .proto(cur)
  );

  ffe_tx_ser #(.LANES(LANES), .BYTE_W(8)) u_tx (
    .clk(clk), .rst(rst), .active(!cs_n && ph == PH_RD), .fall(fall),
    .lanes(lw), .rdata(mem_rdata), .dq_out(dq_out), .dq_oe(dq_oe), .empty(tx_empty)
  );

  assert_we_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);
  assert_no_strobe_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (cs_n && $past(cs_n)) |-> (!mem_we && !mem_re && !op_valid));
  assert_oe_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (cs_n && $past(cs_n)) |-> dq_oe == 0);
  assert_op_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> !op_valid);
endmodule

// File: tb/sim_flash_cmd_front.sv
module sim_flash_cmd_front;
  logic        clk = 0, rst = 1, sck = 0, cs_n = 1;
  logic [7:0]  nv_cfg = 8'hFF, cmd_op, mem_rdata = 0, mem_wdata;
  logic [3:0]  dq_in = 0, dq_out, dq_oe;
  logic [1:0]  proto;
  logic        op_valid, mem_re, mem_we;
  logic [23:0] mem_addr;

  int nchk = 0, nbad = 0, wn = 0, nre = 0, nop = 0, oe_bad = 0;
  logic [23:0] waddr [64];
  logic [7:0]  wdata [64];
  logic [7:0]  last_op = 0;
  logic        prev_cs = 1, done = 0, cpol = 0;
  int          ep = 0;

  always #10 clk = ~clk;

  flash_cmd_front u0 (
    .clk(clk), .rst(rst), .nv_cfg(nv_cfg), .sck(sck), .cs_n(cs_n), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .proto(proto), .op_valid(op_valid),
    .cmd_op(cmd_op), .mem_addr(mem_addr), .mem_re(mem_re), .mem_rdata(mem_rdata),
    .mem_we(mem_we), .mem_wdata(mem_wdata)
  );

  function automatic logic [7:0] pat(logic [23:0] a);
    return {a[3:0], a[7:4]} ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction
  function automatic int ow(int p);
    return p == 0 ? 1 : (p == 1 ? 2 : 4);
  endfunction
  function automatic int bw(int p, logic [7:0] op);
    if (p != 0) return ow(p);
    return op == 8'h3B ? 2 : (op == 8'h6B ? 4 : 1);
  endfunction
  function automatic int pick(logic [7:0] b, int qb, int db);
    return !b[qb] ? 2 : (!b[db] ? 1 : 0);
  endfunction

  always @(posedge clk) if (mem_re) mem_rdata <= pat(mem_addr);

  always @(negedge clk) begin
    if (mem_we && wn < 64) begin waddr[wn] = mem_addr; wdata[wn] = mem_wdata; wn++; end
    if (mem_re) nre++;
    if (op_valid) begin nop++; last_op = cmd_op; end
    if (!rst && cs_n && prev_cs && dq_oe != 0) oe_bad++;
    prev_cs = cs_n;
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (!ok) begin nbad++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  task automatic wclk(int n); repeat (n) @(negedge clk); endtask

  task automatic do_reset(logic [7:0] nv);
    rst = 1; nv_cfg = nv; cs_n = 1; wclk(3); rst = 0; wclk(2);
    ep = pick(nv, 3, 2);
  endtask

  task automatic cs_begin; sck = cpol; wclk(2); cs_n = 0; wclk(2); endtask
  task automatic cs_end; if (!cpol) sck = 0; wclk(2); cs_n = 1; dq_in = 0; wclk(4); endtask

  task automatic send(int w, int n, logic [31:0] val);
    for (int i = n / w - 1; i >= 0; i--) begin
      sck = 0; dq_in = 4'((val >> (i * w)) & ((1 << w) - 1)); wclk(2);
      sck = 1; wclk(2);
    end
  endtask

  task automatic recv(int w, output logic [7:0] b, output bit oe_ok);
    b = 0; oe_ok = 1;
    for (int k = 0; k < 8 / w; k++) begin
      sck = 0; wclk(2);
      if (dq_oe != 4'((1 << w) - 1)) oe_ok = 0;
      b = 8'((b << w) | (dq_out & 4'((1 << w) - 1)));
      sck = 1; wclk(2);
    end
  endtask

  task automatic do_read(logic [7:0] op, logic [23:0] addr, int n, string tag);
    logic [7:0] b; bit ok; int n0 = nop;
    cs_begin; send(ow(ep), 8, op); send(bw(ep, op), 24, addr);
    for (int i = 0; i < n; i++) begin
      recv(bw(ep, op), b, ok);
      chk(b == pat(addr + 24'(i)), tag, b, pat(addr + 24'(i)));
      chk(ok, "R7 lane enable", 0, 1);
    end
    cs_end;
    chk(nop == n0 + 1 && last_op == op, "R11", last_op, op);
  endtask

  task automatic do_write(logic [23:0] addr, int n);
    int w0 = wn; logic [7:0] d [4];
    cs_begin; send(ow(ep), 8, 8'h02); send(bw(ep, 8'h02), 24, addr);
    for (int i = 0; i < n; i++) begin d[i] = 8'($urandom); send(bw(ep, 8'h02), 8, d[i]); end
    cs_end;
    chk(wn == w0 + n, "R6 count", wn - w0, n);
    for (int i = 0; i < n && w0 + i < 64; i++) begin
      chk(waddr[w0 + i] == addr + 24'(i), "R6 addr", waddr[w0 + i], addr + 24'(i));
      chk(wdata[w0 + i] == d[i], "R6 data", wdata[w0 + i], d[i]);
    end
  endtask

  task automatic do_vcfg(logic [7:0] v);
    cs_begin; send(ow(ep), 8, 8'h61); send(bw(ep, 8'h61), 8, v);
    chk(proto == 2'(ep), "R2 held until deselect", proto, ep);
    cs_end; ep = pick(v, 7, 6);
    chk(proto == 2'(ep), "R2 volatile select", proto, ep);
  endtask

  initial begin
    logic [7:0] b; bit ok; int w0, r0, n0;
    void'($urandom(32'd1234));
    do_reset(8'hFF);
    chk(proto == 0, "R1 reset ext", proto, 0);
    chk(dq_oe == 0 && mem_we == 0, "R10 reset idle", dq_oe, 0);
    do_read(8'h03, 24'h12_3456, 3, "R5 R7 ext read");
    do_write(24'h00_0100, 2);
    do_read(8'h3B, 24'hAB_CDEF, 2, "R4 two-lane read");
    do_read(8'h6B, 24'h00_0F0F, 2, "R4 four-lane read");
    do_read(8'h03, 24'hFF_FFFF, 2, "R7 wrap");
    // R8 unknown opcode
    w0 = wn; r0 = nre; n0 = nop; ok = 1;
    cs_begin; send(1, 8, 8'h9F); send(1, 24, 24'h000000);
    for (int k = 0; k < 8; k++) begin sck = 0; wclk(2); if (dq_oe != 0) ok = 0; sck = 1; wclk(2); end
    cs_end;
    chk(ok, "R8 lanes idle", 0, 1);
    chk(wn == w0 && nre == r0 && nop == n0, "R8 no strobes", wn - w0 + nre - r0, 0);
    // R9 aborts
    w0 = wn; r0 = nre;
    cs_begin; send(1, 8, 8'h03); send(1, 10, 10'h155); cs_end;
    chk(nre == r0, "R9 abort in address", nre - r0, 0);
    cs_begin; send(1, 8, 8'h02); send(1, 24, 24'h000200); send(1, 8, 8'hC3); send(1, 3, 3'b101); cs_end;
    chk(wn == w0 + 1, "R9 partial byte dropped", wn - w0, 1);
    cs_begin; send(1, 8, 8'h61); send(1, 5, 5'h00); cs_end;
    chk(proto == 0, "R9 vcfg abort", proto, 0);
    do_read(8'h03, 24'h00_0040, 1, "R9 fresh frame");
    // dual via volatile write
    do_vcfg(8'hBF);
    do_read(8'h03, 24'h34_0001, 2, "R3 dual read");
    do_write(24'h00_5555, 3);
    n0 = nop;
    cs_begin; send(2, 8, 8'h3B); cs_end;
    chk(nop == n0, "R4 multi-lane rejects 0x3B", nop - n0, 0);
    do_vcfg(8'h3F);
    chk(proto == 2, "R2 quad priority", proto, 2);
    do_read(8'h03, 24'h77_8899, 3, "R3 quad read");
    do_write(24'hFF_FFFE, 3);
    // reset discards volatile setting
    do_reset(8'hFF);
    chk(proto == 0, "R1 volatile discarded", proto, 0);
    do_reset(8'hFB); chk(proto == 1, "R1 nv dual", proto, 1);
    do_reset(8'hF7); chk(proto == 2, "R1 nv quad", proto, 2);
    do_reset(8'hF3); chk(proto == 2, "R1 nv quad priority", proto, 2);
    do_reset(8'hFF);
    // R12 idle-high clock
    cpol = 1;
    do_read(8'h03, 24'h01_0203, 2, "R12 idle-high read");
    do_write(24'h00_0300, 2);
    cpol = 0;
    // random mix
    for (int it = 0; it < 30; it++) begin
      logic [7:0] op; int r; logic [23:0] a; int n;
      if ($urandom % 4 == 0) do_vcfg(8'($urandom));
      cpol = 1'($urandom);
      r = $urandom % 4; a = 24'($urandom); n = 1 + $urandom % 3;
      if (r == 0) do_write(a, n);
      else begin
        op = (r == 2 && ep == 0) ? 8'h3B : ((r == 3 && ep == 0) ? 8'h6B : 8'h03);
        do_read(op, a, n, "R7 random read");
      end
    end
    cpol = 0;
    chk(oe_bad == 0, "R10 lanes released", oe_bad, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nchk++; nbad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end
endmodule